// File: doc/BRIEF.md
# Split-Screen Line Address Generator

This block produces the frame-buffer address at which the fetch logic should start reading each displayed line. It supports a display made of two stacked images. The upper image (Screen 1) begins at one base address. The lower image (Screen 2) begins at a second, independent base address. A programmable line boundary decides where the lower image takes over.

A frame-start strobe reloads the line address from the Screen 1 base and clears the line count. Each later line-start strobe moves the address on by the programmed pitch, counted in 16-bit words. When the line count reaches the boundary, the address jumps to the Screen 2 base instead, and a screen-select flag is raised for the rest of the frame.

All programmed values except the Screen 1 base are sampled once per frame, at the frame-start strobe. The Screen 1 base is used directly at that same strobe. Later changes therefore never take effect partway down a frame. A reserved colour-depth code freezes the address output and raises a flag.

Top module: `split_addr_gen`

## Requirements
- R1: After synchronous reset, `line_addr` is 0, `screen2` is 0 and `depth_rsvd` is 0.
- R2: A frame-start strobe with a non-reserved depth code loads `line_addr` with the 20-bit value {`s1_base_hi`[3:0], `s1_base_mid`, `s1_base_lo`} and clears `screen2`. Bits 7..4 of `s1_base_hi` have no effect.
- R3: Each line-start strobe that does not hit the split boundary adds the latched `pitch_words` to `line_addr`. This holds for every depth code 000..101. With no strobe, `line_addr` and `screen2` hold.
- R4: Lines are numbered from 0 at frame start, and Screen 1 is `cmp_line`+1 lines tall. On the strobe that starts line number `cmp_line`+1, `line_addr` loads the latched `s2_base` and `screen2` goes to 1. Later lines advance by the pitch, and `screen2` stays 1 until the next frame start.
- R5: When `cmp_line`+1 is greater than or equal to `disp_lines`, no split happens and `screen2` stays 0 for the whole frame. This includes the reset compare value 3FFh.
- R6: Depth codes 110 and 111 are reserved. A frame start with such a code sets `depth_rsvd` to 1. While the flag is set, `line_addr` and `screen2` hold their last values through frame and line strobes. A later frame start with a valid code clears the flag and loads normally.
- R7: Changes to `cmp_line`, `disp_lines`, `s2_base`, `pitch_words`, `depth_sel` or the Screen 1 base inputs that occur after a frame start have no effect until the next frame start.
- R8: Address arithmetic wraps modulo 2^20.
- R9: When frame-start and line-start are both asserted in the same cycle, the frame start takes precedence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle strobe at the top of a frame |
| line_start | input | 1 | One-cycle strobe at the start of each following line |
| cmp_line | input | 10 | Screen 1 height minus one |
| disp_lines | input | 10 | Vertical display height in lines |
| s1_base_lo | input | 8 | Screen 1 base, bits 7..0 |
| s1_base_mid | input | 8 | Screen 1 base, bits 15..8 |
| s1_base_hi | input | 8 | Screen 1 base, bits 19..16 in [3:0]; [7:4] ignored |
| s2_base | input | 20 | Screen 2 base word address |
| pitch_words | input | 12 | Line pitch in 16-bit words |
| depth_sel | input | 3 | Colour depth: 000=1, 001=2, 010=4, 011=8, 100=15, 101=16 bpp; 110/111 reserved |
| line_addr | output | 20 | Start word address of the current line |
| screen2 | output | 1 | 1 while the current line belongs to Screen 2 |
| depth_rsvd | output | 1 | 1 while the latched depth code is reserved |

## Verification
Every output is registered, so each result appears one clock edge after the strobe that causes it. A new address is due on the edge that samples `frame_start` or `line_start`. The split jump, the `screen2` change and the `depth_rsvd` update are all due on that same edge.

The bench drives each strobe for exactly one cycle, starting on a falling edge. It reads the outputs on the next falling edge, which is half a cycle after the single register stage has updated. Mid-frame changes to the inputs are applied between strobes, so the very next line shows whether the latched values were kept.

// File: rtl/split_addr_pkg.sv
package split_addr_pkg;

    localparam int ADDR_W  = 20;
    localparam int LINE_W  = 10;
    localparam int PITCH_W = 12;
    localparam int BYTE_W  = 8;
    localparam int HI_W    = ADDR_W - 2 * BYTE_W;

    typedef logic [ADDR_W-1:0]  addr_t;
    typedef logic [LINE_W-1:0]  line_t;
    typedef logic [PITCH_W-1:0] pitch_t;

    localparam line_t CMP_RESET = '1;

    typedef enum logic [2:0] {
        DEPTH_1    = 3'd0,
        DEPTH_2    = 3'd1,
        DEPTH_4    = 3'd2,
        DEPTH_8    = 3'd3,
        DEPTH_15   = 3'd4,
        DEPTH_16   = 3'd5,
        DEPTH_RSV6 = 3'd6,
        DEPTH_RSV7 = 3'd7
    } depth_e;

    typedef struct packed {
        line_t  cmp;
        line_t  height;
        addr_t  s2_base;
        pitch_t pitch;
        depth_e depth;
    } frame_cfg_t;

    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_LOAD_S1,
        ACT_ADVANCE,
        ACT_LOAD_S2
    } addr_act_e;

    function automatic logic depth_reserved(input depth_e d);
        return (d == DEPTH_RSV6) || (d == DEPTH_RSV7);
    endfunction

    function automatic addr_t join_base(input logic [BYTE_W-1:0] lo,
                                        input logic [BYTE_W-1:0] mid,
                                        input logic [BYTE_W-1:0] hi);
        return {hi[HI_W-1:0], mid, lo};
    endfunction

    // A split exists only when Screen 1 (cmp+1 lines) is shorter than the display.
    function automatic logic split_enabled(input line_t cmp, input line_t height);
        logic [LINE_W:0] top_lines;
        top_lines = {1'b0, cmp} + (LINE_W+1)'(1);
        return top_lines < {1'b0, height};
    endfunction

endpackage

// File: rtl/split_cfg_latch.sv
module split_cfg_latch
    import split_addr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_start,
    input  frame_cfg_t cfg_d,
    output frame_cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.cmp     <= CMP_RESET;
            cfg_q.height  <= '0;
            cfg_q.s2_base <= '0;
            cfg_q.pitch   <= '0;
            cfg_q.depth   <= DEPTH_1;
        end else if (frame_start) begin
            cfg_q <= cfg_d;
        end
    end

endmodule

// File: rtl/split_line_seq.sv
module split_line_seq
    import split_addr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_start,
    input  logic       line_start,
    input  depth_e     depth_live,
    input  frame_cfg_t cfg_q,
    output addr_act_e  act,
    output logic       screen2,
    output logic       rsvd
);

    line_t line_cnt;
    logic  screen2_q;
    logic  rsvd_q;
    logic  at_boundary;

    assign at_boundary = !screen2_q && (line_cnt == cfg_q.cmp)
                         && split_enabled(cfg_q.cmp, cfg_q.height);

    always_comb begin
        act = ACT_HOLD;
        if (frame_start) begin
            act = depth_reserved(depth_live) ? ACT_HOLD : ACT_LOAD_S1;
        end else if (line_start && !rsvd_q) begin
            act = at_boundary ? ACT_LOAD_S2 : ACT_ADVANCE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_cnt  <= '0;
            screen2_q <= 1'b0;
            rsvd_q    <= 1'b0;
        end else if (frame_start) begin
            line_cnt <= '0;
            rsvd_q   <= depth_reserved(depth_live);
            if (!depth_reserved(depth_live)) begin
                screen2_q <= 1'b0;
            end
        end else if (act == ACT_LOAD_S2) begin
            screen2_q <= 1'b1;
            line_cnt  <= line_cnt + 1'b1;
        end else if (act == ACT_ADVANCE) begin
            line_cnt <= line_cnt + 1'b1;
        end
    end

    assign screen2 = screen2_q;
    assign rsvd    = rsvd_q;

endmodule

// File: rtl/split_addr_dp.sv
module split_addr_dp
    import split_addr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  addr_act_e act,
    input  addr_t     s1_live,
    input  addr_t     s2_base,
    input  pitch_t    pitch,
    output addr_t     line_addr
);

    addr_t addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else begin
            unique case (act)
                ACT_LOAD_S1: addr_q <= s1_live;
                ACT_LOAD_S2: addr_q <= s2_base;
                ACT_ADVANCE: addr_q <= addr_q + ADDR_W'(pitch);
                default:     addr_q <= addr_q;
            endcase
        end
    end

    assign line_addr = addr_q;

endmodule

// File: rtl/split_addr_gen.sv
module split_addr_gen
    import split_addr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        frame_start,
    input  logic        line_start,
    input  logic [9:0]  cmp_line,
    input  logic [9:0]  disp_lines,
    input  logic [7:0]  s1_base_lo,
    input  logic [7:0]  s1_base_mid,
    input  logic [7:0]  s1_base_hi,
    input  logic [19:0] s2_base,
    input  logic [11:0] pitch_words,
    input  logic [2:0]  depth_sel,
    output logic [19:0] line_addr,
    output logic        screen2,
    output logic        depth_rsvd
);

    frame_cfg_t cfg_d;
    frame_cfg_t cfg_q;
    addr_act_e  act;
    addr_t      s1_live;

    always_comb begin
        cfg_d.cmp     = cmp_line;
        cfg_d.height  = disp_lines;
        cfg_d.s2_base = s2_base;
        cfg_d.pitch   = pitch_words;
        cfg_d.depth   = depth_e'(depth_sel);
    end

    assign s1_live = join_base(s1_base_lo, s1_base_mid, s1_base_hi);

    split_cfg_latch u_cfg (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .cfg_d       (cfg_d),
        .cfg_q       (cfg_q)
    );

    split_line_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .line_start  (line_start),
        .depth_live  (cfg_d.depth),
        .cfg_q       (cfg_q),
        .act         (act),
        .screen2     (screen2),
        .rsvd        (depth_rsvd)
    );

    split_addr_dp u_dp (
        .clk       (clk),
        .rst       (rst),
        .act       (act),
        .s1_live   (s1_live),
        .s2_base   (cfg_q.s2_base),
        .pitch     (cfg_q.pitch),
        .line_addr (line_addr)
    );

endmodule

// File: rtl/split_addr_gen_chk.sv
module split_addr_gen_chk (
    input logic        clk,
    input logic        rst,
    input logic        frame_start,
    input logic        line_start,
    input logic [7:0]  s1_base_lo,
    input logic [7:0]  s1_base_mid,
    input logic [7:0]  s1_base_hi,
    input logic [2:0]  depth_sel,
    input logic [19:0] line_addr,
    input logic        screen2,
    input logic        depth_rsvd
);

    AST_FRAME_LOAD: assert property (@(posedge clk) disable iff (rst)
        (frame_start && depth_sel < 3'd6) |=>
        (line_addr == {$past(s1_base_hi[3:0]), $past(s1_base_mid), $past(s1_base_lo)}) && !screen2); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!frame_start && !line_start) |=> ($stable(line_addr) && $stable(screen2))); // R3

    AST_SCREEN2_STICKY: assert property (@(posedge clk) disable iff (rst)
        (screen2 && !frame_start) |=> screen2); // R4

    AST_RSVD_FLAG: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (depth_rsvd == ($past(depth_sel) >= 3'd6))); // R6

    AST_RSVD_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (depth_rsvd && !frame_start) |=> ($stable(line_addr) && $stable(screen2))); // R6

endmodule

bind split_addr_gen split_addr_gen_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .line_start  (line_start),
    .s1_base_lo  (s1_base_lo),
    .s1_base_mid (s1_base_mid),
    .s1_base_hi  (s1_base_hi),
    .depth_sel   (depth_sel),
    .line_addr   (line_addr),
    .screen2     (screen2),
    .depth_rsvd  (depth_rsvd)
);

// File: tb/tb_split_addr_gen.sv
module tb_split_addr_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_start = 1'b0;
    logic        line_start = 1'b0;
    logic [9:0]  cmp_line = 10'h3FF;
    logic [9:0]  disp_lines = 10'd0;
    logic [7:0]  s1_base_lo = '0;
    logic [7:0]  s1_base_mid = '0;
    logic [7:0]  s1_base_hi = '0;
    logic [19:0] s2_base = '0;
    logic [11:0] pitch_words = '0;
    logic [2:0]  depth_sel = 3'd3;
    logic [19:0] line_addr;
    logic        screen2;
    logic        depth_rsvd;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    split_addr_gen dut (
        .clk(clk), .rst(rst), .frame_start(frame_start), .line_start(line_start),
        .cmp_line(cmp_line), .disp_lines(disp_lines),
        .s1_base_lo(s1_base_lo), .s1_base_mid(s1_base_mid), .s1_base_hi(s1_base_hi),
        .s2_base(s2_base), .pitch_words(pitch_words), .depth_sel(depth_sel),
        .line_addr(line_addr), .screen2(screen2), .depth_rsvd(depth_rsvd)
    );

    task automatic chk(input string req, input string what,
                       input logic [19:0] act, input logic [19:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic set_s1(input logic [19:0] a, input logic [3:0] junk);
        s1_base_lo  = a[7:0];
        s1_base_mid = a[15:8];
        s1_base_hi  = {junk, a[19:16]};
    endtask

    task automatic strobe(input logic fs, input logic ls);
        @(negedge clk);
        frame_start = fs;
        line_start  = ls;
        @(negedge clk);
        frame_start = 1'b0;
        line_start  = 1'b0;
    endtask

    task automatic lines(input int n);
        for (int i = 0; i < n; i++) strobe(1'b0, 1'b1);
    endtask

    task automatic t_reset();
        chk("R1", "line_addr", line_addr, 20'h0);
        chk("R1", "screen2", 20'(screen2), 20'h0);
        chk("R1", "depth_rsvd", 20'(depth_rsvd), 20'h0);
    endtask

    task automatic t_frame_load();
        depth_sel = 3'd3; disp_lines = 10'd100; cmp_line = 10'h3FF;
        set_s1(20'h51234, 4'hF);
        strobe(1'b1, 1'b0);
        chk("R2", "s1 base assembly, hi[7:4] ignored", line_addr, 20'h51234);
        chk("R2", "screen2 clear", 20'(screen2), 20'h0);
        repeat (3) @(negedge clk);
        chk("R3", "idle hold", line_addr, 20'h51234);
    endtask

    task automatic t_advance();
        pitch_words = 12'h050; disp_lines = 10'd100; cmp_line = 10'h3FF;
        for (int d = 0; d < 6; d++) begin
            depth_sel = 3'(d);
            set_s1(20'h10000 + 20'(d * 'h100), 4'h0);
            strobe(1'b1, 1'b0);
            lines(3);
            chk("R3", $sformatf("advance depth %0d", d), line_addr,
                20'h10000 + 20'(d * 'h100) + 20'h0F0);
        end
    endtask

    task automatic t_split();
        depth_sel = 3'd3; disp_lines = 10'd10; cmp_line = 10'd3;
        set_s1(20'h01000, 4'h0); s2_base = 20'h80000; pitch_words = 12'h040;
        strobe(1'b1, 1'b0);
        lines(3);
        chk("R4", "last screen1 line addr", line_addr, 20'h010C0);
        chk("R4", "last screen1 line flag", 20'(screen2), 20'h0);
        lines(1);
        chk("R4", "split loads s2 base", line_addr, 20'h80000);
        chk("R4", "screen2 set", 20'(screen2), 20'h1);
        lines(1);
        chk("R4", "screen2 advances", line_addr, 20'h80040);
        chk("R4", "screen2 sticky", 20'(screen2), 20'h1);
    endtask

    task automatic t_nosplit();
        depth_sel = 3'd3; disp_lines = 10'd10; cmp_line = 10'd9;
        set_s1(20'h01000, 4'h0); s2_base = 20'h80000; pitch_words = 12'h040;
        strobe(1'b1, 1'b0);
        lines(12);
        chk("R5", "cmp+1==height no split flag", 20'(screen2), 20'h0);
        chk("R5", "cmp+1==height addr", line_addr, 20'h01300);
        cmp_line = 10'd8;
        strobe(1'b1, 1'b0);
        lines(9);
        chk("R4", "cmp+1==height-1 splits", line_addr, 20'h80000);
        chk("R4", "cmp+1==height-1 flag", 20'(screen2), 20'h1);
        cmp_line = 10'h3FF; disp_lines = 10'h3FF;
        strobe(1'b1, 1'b0);
        lines(12);
        chk("R5", "cmp 3FF no split", 20'(screen2), 20'h0);
        chk("R5", "cmp 3FF addr", line_addr, 20'h01300);
    endtask

    task automatic t_reserved();
        cmp_line = 10'h3FF; disp_lines = 10'd100; pitch_words = 12'h010;
        depth_sel = 3'd3; set_s1(20'h02000, 4'h0);
        strobe(1'b1, 1'b0);
        chk("R6", "valid frame before reserved", line_addr, 20'h02000);
        depth_sel = 3'd6; set_s1(20'h05000, 4'h0);
        strobe(1'b1, 1'b0);
        chk("R6", "code 110 flag", 20'(depth_rsvd), 20'h1);
        chk("R6", "code 110 frozen", line_addr, 20'h02000);
        lines(2);
        chk("R6", "frozen through lines", line_addr, 20'h02000);
        depth_sel = 3'd7;
        strobe(1'b1, 1'b0);
        chk("R6", "code 111 flag", 20'(depth_rsvd), 20'h1);
        chk("R6", "code 111 frozen", line_addr, 20'h02000);
        depth_sel = 3'd1;
        strobe(1'b1, 1'b0);
        chk("R6", "flag clears", 20'(depth_rsvd), 20'h0);
        chk("R6", "valid frame loads again", line_addr, 20'h05000);
    endtask

    task automatic t_midframe();
        depth_sel = 3'd3; disp_lines = 10'd8; cmp_line = 10'd1;
        set_s1(20'h03000, 4'h0); s2_base = 20'h00200; pitch_words = 12'h010;
        strobe(1'b1, 1'b0);
        pitch_words = 12'h099; s2_base = 20'h00300; cmp_line = 10'd5;
        set_s1(20'h07000, 4'h0); depth_sel = 3'd6;
        lines(1);
        chk("R7", "old pitch kept", line_addr, 20'h03010);
        chk("R7", "reserved code mid-frame no effect", 20'(depth_rsvd), 20'h0);
        lines(1);
        chk("R7", "old cmp and s2 kept", line_addr, 20'h00200);
        chk("R7", "old cmp split flag", 20'(screen2), 20'h1);
        depth_sel = 3'd3;
        strobe(1'b1, 1'b0);
        chk("R7", "new s1 at next frame", line_addr, 20'h07000);
        lines(1);
        chk("R7", "new pitch at next frame", line_addr, 20'h07099);
    endtask

    task automatic t_wrap();
        depth_sel = 3'd5; cmp_line = 10'h3FF; disp_lines = 10'd100;
        set_s1(20'hFFFF0, 4'h0); pitch_words = 12'h020;
        strobe(1'b1, 1'b0);
        lines(1);
        chk("R8", "wrap mod 2^20", line_addr, 20'h00010);
    endtask

    task automatic t_both();
        depth_sel = 3'd3; cmp_line = 10'd0; disp_lines = 10'd8;
        set_s1(20'h04444, 4'h0); s2_base = 20'h09000; pitch_words = 12'h010;
        strobe(1'b1, 1'b0);
        lines(2);
        strobe(1'b1, 1'b1);
        chk("R9", "frame wins over line", line_addr, 20'h04444);
        chk("R9", "screen2 cleared", 20'(screen2), 20'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_frame_load();
        t_advance();
        t_split();
        t_nosplit();
        t_reserved();
        t_midframe();
        t_wrap();
        t_both();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1000000;
        checks++;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule